// File: doc/BRIEF.md
# Page Write and Self-Timed Program Controller

This block sits behind the serial front end of a small non-volatile memory. When a write command is accepted, the front end loads the start address. It then delivers each received data byte with a one-cycle strobe. The controller collects these bytes in a page buffer. Only the low address bits advance inside the page, so any bytes past the page size wrap around and replace earlier entries.

When chip select is released, the controller decides whether to commit. It commits only if all of the following hold:
- the write-enable latch is set;
- at least one whole byte has arrived;
- no partial byte is pending.

If it does not commit, the buffered bytes are dropped.

When it commits, it runs a self-timed program cycle of a fixed number of system clocks. In the first cycles of that window, the controller scans the page. For each buffered slot it asks an external protection block about that slot's address. It writes the slot to the array port only when the address is not protected. Busy is high for the whole window. On the last busy cycle the controller pulses a request to clear the write-enable latch.

Top module: `page_prog_ctrl`

## Requirements
- R1: After reset, `busy`, `mem_we` and `wel_clr` are low.
- R2: The k-th byte after an address load (k counted from 0) is committed to the address whose upper bits equal the upper bits of the start address. Its low `PAGE_W` bits are (start low bits + k) mod 2^`PAGE_W`.
- R3: When more than 2^`PAGE_W` bytes are sent, each page slot holds the last byte sent to it. Each received slot is written exactly once per cycle, and slots never received are not written.
- R4: If `mid_byte` is high in the cycle where `cs_n` rises, no program cycle starts and nothing is written.
- R5: If `wel` is low in the cycle where `cs_n` rises, no program cycle starts and nothing is written.
- R6: If `cs_n` rises after an address load with no complete byte received, no program cycle starts.
- R7: After a commit, `busy` is high for exactly `PROG_CYCLES` consecutive clock cycles, starting the cycle after the edge where the `cs_n` rise is sampled.
- R8: `wel_clr` pulses for exactly one cycle per program cycle, on the last cycle in which `busy` is high, and never outside a program cycle.
- R9: A slot is not written when `prot_hit` is high for its address on `prot_addr`.
- R10: While `busy` is high, address loads, byte strobes and `cs_n` edges are ignored. The page being programmed is unchanged, and no second cycle follows.
- R11: `mem_we` is high only while `busy` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| cs_n | input | 1 | Chip select, active low, synchronous to clk |
| wel | input | 1 | Write-enable latch state |
| mid_byte | input | 1 | High when serial bits have arrived since the last complete byte |
| addr_load | input | 1 | Start-address strobe that opens a page write |
| start_addr | input | ADDR_W | Start address of the page write |
| byte_stb | input | 1 | One-cycle strobe: a data byte is complete |
| byte_data | input | 8 | Data byte qualified by byte_stb |
| prot_hit | input | 1 | Protection answer for prot_addr (1 = protected) |
| prot_addr | output | ADDR_W | Address queried against the protection block |
| mem_we | output | 1 | Array write strobe |
| mem_addr | output | ADDR_W | Array write address |
| mem_wdata | output | 8 | Array write data |
| busy | output | 1 | Program cycle in progress |
| wel_clr | output | 1 | One-cycle pulse that clears the write-enable latch |

## Verification
The program window has a fixed length, so a timer or state fault appears at the ports within one window. It shows as a wrong busy length, a missing or misplaced latch-clear pulse, or a cycle that starts after an abandoned command. A corrupted slot pointer or valid mask shows up only after the scan, as array contents or a write count that differs from the arithmetic page model. That is why the bench sweeps start offsets and byte counts across the wrap point, and compares the whole array after every window.

// File: rtl/page_prog_ctrl.sv
module page_prog_ctrl #(
  parameter int ADDR_W      = 10,
  parameter int PAGE_W      = 5,
  parameter int PROG_CYCLES = 250000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              wel,
  input  logic              mid_byte,
  input  logic              addr_load,
  input  logic [ADDR_W-1:0] start_addr,
  input  logic              byte_stb,
  input  logic [7:0]        byte_data,
  input  logic              prot_hit,
  output logic [ADDR_W-1:0] prot_addr,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [7:0]        mem_wdata,
  output logic              busy,
  output logic              wel_clr
);
  localparam int PAGE_BYTES = 1 << PAGE_W;
  localparam int HI_W       = ADDR_W - PAGE_W;
  localparam int IDX_W      = PAGE_W + 1;
  localparam int TMR_W      = $clog2(PROG_CYCLES + 1);

  logic                  cs_q, collecting;
  logic [HI_W-1:0]       page_q;
  logic [PAGE_W-1:0]     ptr_q;
  logic [7:0]            pg_data [PAGE_BYTES];
  logic [PAGE_BYTES-1:0] valid_q;
  logic                  busy_q;
  logic [TMR_W-1:0]      timer_q;
  logic [IDX_W-1:0]      scan_q;

  wire [PAGE_W-1:0] slot      = scan_q[PAGE_W-1:0];
  wire              scan_live = busy_q && !scan_q[PAGE_W];
  wire              timer_done = busy_q && (timer_q == TMR_W'(PROG_CYCLES - 1));
  wire              cs_rise   = cs_n && !cs_q;
  wire              load_ok   = !busy_q && !cs_rise && addr_load && !cs_n;
  wire              wr_byte   = !busy_q && !cs_rise && !load_ok && byte_stb && collecting && !cs_n;
  wire              commit    = !busy_q && cs_rise && collecting && (|valid_q) && !mid_byte && wel;

  assign prot_addr = {page_q, slot};
  assign mem_addr  = prot_addr;
  assign mem_wdata = pg_data[slot];
  assign mem_we    = scan_live && valid_q[slot] && !prot_hit;
  assign busy      = busy_q;
  assign wel_clr   = timer_done;

  always_ff @(posedge clk) begin
    if (wr_byte) pg_data[ptr_q] <= byte_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_q       <= 1'b1;
      collecting <= 1'b0;
      page_q     <= '0;
      ptr_q      <= '0;
      valid_q    <= '0;
      busy_q     <= 1'b0;
      timer_q    <= '0;
      scan_q     <= '0;
    end else begin
      cs_q <= cs_n;
      if (busy_q) begin
        timer_q <= timer_q + 1'b1;
        if (scan_live) scan_q <= scan_q + 1'b1;
        if (timer_done) begin
          busy_q  <= 1'b0;
          valid_q <= '0;
        end
      end else if (commit) begin
        busy_q     <= 1'b1;
        timer_q    <= '0;
        scan_q     <= '0;
        collecting <= 1'b0;
      end else if (cs_rise) begin
        collecting <= 1'b0;
        valid_q    <= '0;
      end else if (load_ok) begin
        collecting <= 1'b1;
        page_q     <= start_addr[ADDR_W-1:PAGE_W];
        ptr_q      <= start_addr[PAGE_W-1:0];
        valid_q    <= '0;
      end else if (wr_byte) begin
        valid_q[ptr_q] <= 1'b1;
        ptr_q          <= ptr_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/page_prog_chk.sv
module page_prog_chk (
  input logic clk,
  input logic rst_n,
  input logic cs_n,
  input logic wel,
  input logic mid_byte,
  input logic busy,
  input logic mem_we,
  input logic wel_clr,
  input logic prot_hit
);
  assert_we_in_busy_R11: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> busy);
  assert_no_write_protected_R9: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> !prot_hit);
  assert_clr_inside_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
    wel_clr |-> busy);
  assert_clr_ends_cycle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    wel_clr |=> !busy);
  assert_busy_fall_after_clr_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> $past(wel_clr));
  assert_commit_gate_R4_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> ($past(cs_n) && $past(wel) && !$past(mid_byte)));
endmodule

bind page_prog_ctrl page_prog_chk chk_i (
  .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .wel(wel), .mid_byte(mid_byte),
  .busy(busy), .mem_we(mem_we), .wel_clr(wel_clr), .prot_hit(prot_hit)
);

// File: tb/page_prog_ctrl_tb.sv
module page_prog_ctrl_tb_top;
  localparam int AW = 10;
  localparam int PW = 5;
  localparam int PB = 1 << PW;
  localparam int PC = 40;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs_n = 1'b1, wel = 1'b0, mid_byte = 1'b0, addr_load = 1'b0, byte_stb = 1'b0;
  logic [AW-1:0] start_addr = '0;
  logic [7:0] byte_data = '0;
  logic prot_hit;
  logic [AW-1:0] prot_addr, mem_addr;
  logic mem_we, busy, wel_clr;
  logic [7:0] mem_wdata;
  int prot_lo = 1 << AW;

  int tests = 0, fails = 0, wcount = 0;
  logic [7:0] obs [1 << AW];
  logic [7:0] expa [1 << AW];

  always #10 clk = ~clk;

  assign prot_hit = (int'(prot_addr) >= prot_lo);

  page_prog_ctrl #(.ADDR_W(AW), .PAGE_W(PW), .PROG_CYCLES(PC)) dut_i (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .wel(wel), .mid_byte(mid_byte),
    .addr_load(addr_load), .start_addr(start_addr), .byte_stb(byte_stb),
    .byte_data(byte_data), .prot_hit(prot_hit), .prot_addr(prot_addr),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .busy(busy), .wel_clr(wel_clr));

  always @(posedge clk) if (mem_we) begin
    obs[mem_addr] <= mem_wdata;
    wcount = wcount + 1;
  end

  task automatic check(input string tag, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic trial(input int page, input int start, input int len, input int seed,
                       input bit midb, input bit welv, input int plo, input bit intrude,
                       input string tag);
    logic [7:0] tmp [PB];
    bit tv [PB];
    int exp_w = 0, bcnt = 0, ccnt = 0, clr_at = -1, last_busy = -1, mism = 0;
    bit go;
    for (int i = 0; i < PB; i++) tv[i] = 0;
    prot_lo = plo;
    wcount = 0;
    @(negedge clk); cs_n = 0; wel = welv;
    @(negedge clk); addr_load = 1; start_addr = AW'(page * PB + start);
    @(negedge clk); addr_load = 0;
    for (int k = 0; k < len; k++) begin
      byte_stb = 1; byte_data = 8'((seed * 37 + k * 11 + 5) & 255);
      tmp[(start + k) % PB] = byte_data; tv[(start + k) % PB] = 1;
      @(negedge clk); byte_stb = 0;
      @(negedge clk);
    end
    mid_byte = midb;
    cs_n = 1;
    go = welv && !midb && (len > 0);
    if (go) for (int i = 0; i < PB; i++)
      if (tv[i] && (page * PB + i) < plo) begin
        expa[page * PB + i] = tmp[i]; exp_w++;
      end
    for (int c = 0; c < PC + 30; c++) begin
      @(negedge clk);
      if (c == 0) mid_byte = 0;
      if (intrude && c == 3) begin cs_n = 0; end
      if (intrude && c == 4) begin addr_load = 1; start_addr = AW'(((page + 1) % 32) * PB); end
      if (intrude && c == 5) begin addr_load = 0; byte_stb = 1; byte_data = 8'hA5; end
      if (intrude && c == 6) begin byte_stb = 0; cs_n = 1; end
      if (busy) begin bcnt++; last_busy = c; end
      if (wel_clr) begin ccnt++; clr_at = c; end
    end
    wel = 0;
    check({tag, " busy length"}, bcnt, go ? PC : 0);
    check("R8 wel_clr pulse count", ccnt, go ? 1 : 0);
    if (go) check("R8 wel_clr on last busy cycle", clr_at, last_busy);
    for (int a = 0; a < (1 << AW); a++) if (obs[a] !== expa[a]) mism++;
    check({tag, " array mismatches"}, mism, 0);
    check({tag, " write count"}, wcount, exp_w);
  endtask

  initial begin
    #(20 * 150000);
    fails++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    for (int a = 0; a < (1 << AW); a++) begin obs[a] = 0; expa[a] = 0; end
    repeat (3) @(negedge clk);
    check("R1 busy after reset", busy, 0);
    check("R1 mem_we after reset", mem_we, 0);
    check("R1 wel_clr after reset", wel_clr, 0);
    rst_n = 1;
    @(negedge clk);
    begin
      int lens [7] = '{1, 2, 5, 31, 32, 33, 45};
      int sts [3] = '{0, 13, 31};
      int n = 0;
      foreach (lens[i]) foreach (sts[j]) begin
        n++;
        trial((n * 7) % 32, sts[j], lens[i], n, 0, 1, 1 << AW, 0,
              lens[i] > PB ? "R3 wrap" : "R2 place R7");
      end
    end
    trial(4, 10, 6, 90, 1, 1, 1 << AW, 0, "R4 mid-byte");
    trial(5, 3, 8, 91, 0, 0, 1 << AW, 0, "R5 no wel");
    trial(6, 3, 0, 92, 0, 1, 1 << AW, 0, "R6 no byte");
    trial(9, 0, 32, 93, 0, 1, 9 * PB + 16, 0, "R9 half protected");
    trial(10, 20, 40, 94, 0, 1, 0, 0, "R9 all protected");
    trial(12, 28, 12, 95, 0, 1, 1 << AW, 1, "R10 R11 busy ignores");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule